// File: doc/BRIEF.md
# XOR Descriptor Execution Engine

This block takes one already-fetched 128-byte work descriptor, decodes it and carries it out against a simple request/grant memory port that moves one 32-bit word per grant. It handles three operations. A no-op moves no data. A memory copy moves a buffer from a source to a destination. A parity XOR reads up to eight source buffers and writes their bitwise XOR to one destination. When the work is finished, the block raises a one-cycle completion pulse. The pulse carries the descriptor's identifier, its interrupt-on-done flag and an error bit.

The descriptor arrives as 32 words on a valid/ready handshake. The block accepts a new descriptor only while it is idle. Buffer addresses are 48 bits wide. The copy source and the destination each take a low word and a high halfword. XOR source addresses are packed two buffers to three words, and the two buffers share one word that holds both high halves. Operation codes that the block does not execute, and XOR descriptors that are malformed, still complete. They make no memory access and report an error.

Top module: `xor_desc_engine`

## Requirements
- R1: `desc_ready` is 1 after reset and whenever the block is idle. A descriptor is taken in a cycle where `desc_valid` and `desc_ready` are both 1. `desc_ready` stays 0 from that edge until the cycle after the completion pulse.
- R2: `done` is high for exactly one cycle per accepted descriptor. During that cycle, `done_id` equals bits [15:0] of word 0 and `done_irq` equals bit 27 of word 2 (the control word). All other bits of word 0, word 1 and the reserved words 20..31 have no effect.
- R3: Operation code 0 in control-word bits [31:28] is a no-op. It completes one cycle after acceptance with `done_err`=0 and no memory request.
- R4: Operation code 1 is a copy. The source address is word 4 (low 32 bits) plus word 5 [15:0] (bits 47:32). The destination is word 6 plus word 7 [15:0]. For each data word k, in ascending order, the block reads source+4k and then writes that data to destination+4k.
- R5: Operation code 6 is an XOR. It requires P-enable (control bit 17) set and a buffer count in control bits [25:22] of 1 to 8. Buffers 2p and 2p+1 take their low 32 bits from words 8+3p and 9+3p. Their bits 47:32 come from word 10+3p, in [15:0] for the even buffer and [31:16] for the odd buffer. For each data word k, the block reads every buffer at address+4k in ascending buffer order, then makes one write of their XOR to destination+4k. The destination is taken from the same words as for the copy.
- R6: The byte count in word 3 is rounded up to whole 32-bit words. A count of 0 completes one cycle after acceptance, with no memory request and `done_err`=0.
- R7: Operation codes 2, 3, 4, 5, 7, 8 and 9..15 complete one cycle after acceptance, with `done_err`=1 and no memory request.
- R8: An XOR with P-enable clear, or with a buffer count of 0 or more than 8, completes one cycle after acceptance, with `done_err`=1 and no memory request.
- R9: While `mem_req` is 1 and `mem_gnt` is 0, the request, address, write enable and write data stay unchanged into the next cycle. Read data is taken in the grant cycle.
- R10: `mem_req` is 0 whenever the block is idle or signalling completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Engine idle, descriptor can be taken |
| desc_words | input | 1024 | Descriptor, word i in bits [32i+31:32i] |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access performed this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | 16 | Identifier returned unchanged |
| done_irq | output | 1 | Interrupt-on-done flag of the descriptor |
| done_err | output | 1 | Descriptor rejected |

## Verification
The checker watches several behaviours on every cycle. These are the handshake exclusion, the one-cycle completion pulse and the identifier and flag it returns, the silence of the memory port around idle and completion, the stability of a stalled request, the rule that each write is preceded by exactly the expected number of source reads, and the absence of memory traffic for no-op and rejected descriptors. Other behaviours only the bench's scenarios can show. These are the actual addresses formed from the packed 48-bit fields, the ascending order of buffers and words, the XOR data written, the rounding of odd byte counts, and the one-cycle latency of empty and rejected work. The bench shows them by sweeping every operation code, every buffer count with both P-enable settings, and a range of byte counts, under random grant stalls.

// File: rtl/xde_pkg.sv
package xde_pkg;

    // descriptor geometry
    localparam int XDE_DW  = 32;   // words per descriptor
    localparam int XDE_AW  = 48;   // buffer address width
    localparam int XDE_CW  = 31;   // data word counter width
    localparam int XDE_IDW = 16;   // identifier width

    // word positions inside the descriptor
    localparam int W_ID   = 0;
    localparam int W_CTRL = 2;
    localparam int W_LEN  = 3;
    localparam int W_SRCA = 4;
    localparam int W_BUF  = 8;

    // control word fields
    localparam int MODE_LO = 28;
    localparam int IRQ_BIT = 27;
    localparam int NBUF_LO = 22;
    localparam int PEN_BIT = 17;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_COPY    = 4'd1,
        OP_FILL    = 4'd2,
        OP_INIT    = 4'd3,
        OP_CMP     = 4'd4,
        OP_CRC     = 4'd5,
        OP_XOR     = 4'd6,
        OP_PQ_GEN  = 4'd7,
        OP_PQ_REC  = 4'd8
    } xde_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } xde_state_e;

endpackage

// File: rtl/xde_decode.sv
module xde_decode
    import xde_pkg::*;
#(
    parameter int MAX_SRC   = 8,
    parameter int SRC_IDX_W = 3
) (
    input  logic [XDE_DW*32-1:0]             desc_words,
    output logic                             bad,
    output logic                             moves,
    output logic [SRC_IDX_W-1:0]             last_src,
    output logic [MAX_SRC-1:0][XDE_AW-1:0]   srcs,
    output logic [XDE_AW-1:0]                dest,
    output logic [XDE_CW-1:0]                nwords,
    output logic [XDE_IDW-1:0]               id,
    output logic                             irq
);

    localparam int PAIRS    = MAX_SRC / 2;
    localparam int BUF_END  = W_BUF + 3 * PAIRS;

    logic [XDE_DW-1:0][31:0]           w;
    logic [3:0]                        mode;
    logic [3:0]                        nbuf;
    logic                              p_en;
    logic [MAX_SRC-1:0][XDE_AW-1:0]    buf_addr;
    logic [XDE_AW-1:0]                 copy_src;
    logic [31:0]                       len;

    assign w        = desc_words;
    assign mode     = w[W_CTRL][MODE_LO +: 4];
    assign nbuf     = w[W_CTRL][NBUF_LO +: 4];
    assign p_en     = w[W_CTRL][PEN_BIT];
    assign irq      = w[W_CTRL][IRQ_BIT];
    assign id       = w[W_ID][XDE_IDW-1:0];
    assign len      = w[W_LEN];
    assign copy_src = {w[W_SRCA+1][15:0], w[W_SRCA]};
    assign dest     = {w[W_SRCA+3][15:0], w[W_SRCA+2]};

    // round the byte count up to whole words
    assign nwords = {1'b0, len[31:2]} + XDE_CW'(|len[1:0]);

    // paired buffer address unpacking: low words first, shared high word last
    for (genvar i = 0; i < MAX_SRC; i++) begin : g_buf
        localparam int BW = W_BUF + 3 * (i / 2);
        if ((i % 2) == 0) begin : g_even
            assign buf_addr[i] = {w[BW+2][15:0], w[BW]};
        end else begin : g_odd
            assign buf_addr[i] = {w[BW+2][31:16], w[BW+1]};
        end
        if (i == 0) begin : g_first
            assign srcs[i] = (mode == OP_COPY) ? copy_src : buf_addr[i];
        end else begin : g_rest
            assign srcs[i] = buf_addr[i];
        end
    end

    always_comb begin
        bad      = 1'b0;
        moves    = 1'b0;
        last_src = '0;
        case (mode)
            OP_NOP: begin
                moves = 1'b0;
            end
            OP_COPY: begin
                moves = 1'b1;
            end
            OP_XOR: begin
                if (!p_en || nbuf == 4'd0 || int'(nbuf) > MAX_SRC) begin
                    bad = 1'b1;
                end else begin
                    moves    = 1'b1;
                    last_src = SRC_IDX_W'(nbuf - 4'd1);
                end
            end
            default: begin
                bad = 1'b1;
            end
        endcase
    end

    // fields the engine deliberately leaves alone
    logic unused_fields;
    assign unused_fields = ^{w[1], w[W_ID][31:XDE_IDW], w[W_CTRL][26],
                             w[W_CTRL][21:18], w[W_CTRL][16:0],
                             w[W_SRCA+1][31:16], w[W_SRCA+3][31:16],
                             w[XDE_DW-1:BUF_END]};

endmodule

// File: rtl/xde_sequencer.sv
module xde_sequencer
    import xde_pkg::*;
#(
    parameter int MAX_SRC   = 8,
    parameter int SRC_IDX_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             desc_valid,
    output logic                             desc_ready,
    input  logic                             dec_bad,
    input  logic                             dec_moves,
    input  logic [SRC_IDX_W-1:0]             dec_last_src,
    input  logic [MAX_SRC-1:0][XDE_AW-1:0]   dec_srcs,
    input  logic [XDE_AW-1:0]                dec_dest,
    input  logic [XDE_CW-1:0]                dec_nwords,
    input  logic [XDE_IDW-1:0]               dec_id,
    input  logic                             dec_irq,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [XDE_AW-1:0]                mem_addr,
    output logic [31:0]                      mem_wdata,
    input  logic                             mem_gnt,
    input  logic [31:0]                      mem_rdata,
    output logic                             done,
    output logic [XDE_IDW-1:0]               done_id,
    output logic                             done_irq,
    output logic                             done_err
);

    typedef struct packed {
        xde_state_e                        st;
        logic [MAX_SRC-1:0][XDE_AW-1:0]    srcs;
        logic [XDE_AW-1:0]                 dest;
        logic [SRC_IDX_W-1:0]              last_src;
        logic [SRC_IDX_W-1:0]              sidx;
        logic [XDE_CW-1:0]                 nwords;
        logic [XDE_CW-1:0]                 widx;
        logic [31:0]                       acc;
        logic [XDE_IDW-1:0]                id;
        logic                              irq;
        logic                              err;
    } seq_t;

    seq_t q, d;
    logic [XDE_AW-1:0] off;

    assign off = XDE_AW'({q.widx, 2'b00});

    always_comb begin
        d          = q;
        desc_ready = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = q.acc;
        case (q.st)
            ST_IDLE: begin
                desc_ready = 1'b1;
                if (desc_valid) begin
                    d.srcs     = dec_srcs;
                    d.dest     = dec_dest;
                    d.last_src = dec_last_src;
                    d.nwords   = dec_nwords;
                    d.id       = dec_id;
                    d.irq      = dec_irq;
                    d.err      = dec_bad;
                    d.sidx     = '0;
                    d.widx     = '0;
                    d.acc      = '0;
                    if (dec_bad || !dec_moves || dec_nwords == '0) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = q.srcs[q.sidx] + off;
                if (mem_gnt) begin
                    d.acc = q.acc ^ mem_rdata;
                    if (q.sidx == q.last_src) begin
                        d.st = ST_WRITE;
                    end else begin
                        d.sidx = q.sidx + SRC_IDX_W'(1);
                    end
                end
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.dest + off;
                if (mem_gnt) begin
                    d.acc  = '0;
                    d.sidx = '0;
                    if (q.widx + XDE_CW'(1) == q.nwords) begin
                        d.st = ST_DONE;
                    end else begin
                        d.widx = q.widx + XDE_CW'(1);
                        d.st   = ST_READ;
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done     = (q.st == ST_DONE);
    assign done_id  = q.id;
    assign done_irq = q.irq;
    assign done_err = q.err;

endmodule

// File: rtl/xor_desc_engine.sv
module xor_desc_engine
    import xde_pkg::*;
#(
    parameter int MAX_SRC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   desc_valid,
    output logic                   desc_ready,
    input  logic [XDE_DW*32-1:0]   desc_words,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [XDE_AW-1:0]      mem_addr,
    output logic [31:0]            mem_wdata,
    input  logic                   mem_gnt,
    input  logic [31:0]            mem_rdata,
    output logic                   done,
    output logic [XDE_IDW-1:0]     done_id,
    output logic                   done_irq,
    output logic                   done_err
);

    localparam int SRC_IDX_W = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1;

    logic                             dec_bad;
    logic                             dec_moves;
    logic [SRC_IDX_W-1:0]             dec_last_src;
    logic [MAX_SRC-1:0][XDE_AW-1:0]   dec_srcs;
    logic [XDE_AW-1:0]                dec_dest;
    logic [XDE_CW-1:0]                dec_nwords;
    logic [XDE_IDW-1:0]               dec_id;
    logic                             dec_irq;

    xde_decode #(
        .MAX_SRC   (MAX_SRC),
        .SRC_IDX_W (SRC_IDX_W)
    ) u_decode (
        .desc_words (desc_words),
        .bad        (dec_bad),
        .moves      (dec_moves),
        .last_src   (dec_last_src),
        .srcs       (dec_srcs),
        .dest       (dec_dest),
        .nwords     (dec_nwords),
        .id         (dec_id),
        .irq        (dec_irq)
    );

    xde_sequencer #(
        .MAX_SRC   (MAX_SRC),
        .SRC_IDX_W (SRC_IDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .dec_bad      (dec_bad),
        .dec_moves    (dec_moves),
        .dec_last_src (dec_last_src),
        .dec_srcs     (dec_srcs),
        .dec_dest     (dec_dest),
        .dec_nwords   (dec_nwords),
        .dec_id       (dec_id),
        .dec_irq      (dec_irq),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .done         (done),
        .done_id      (done_id),
        .done_irq     (done_irq),
        .done_err     (done_err)
    );

endmodule

// File: rtl/xde_checks.sv
module xde_checks
    import xde_pkg::*;
#(
    parameter int MAX_SRC = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   desc_valid,
    input logic                   desc_ready,
    input logic [XDE_DW*32-1:0]   desc_words,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [XDE_AW-1:0]      mem_addr,
    input logic [31:0]            mem_wdata,
    input logic                   mem_gnt,
    input logic [31:0]            mem_rdata,
    input logic                   done,
    input logic [XDE_IDW-1:0]     done_id,
    input logic                   done_irq,
    input logic                   done_err
);

    logic                 accept;
    logic [3:0]           in_mode;
    logic [3:0]           in_nbuf;
    logic [XDE_IDW-1:0]   lat_id;
    logic                 lat_irq;
    logic                 lat_nop;
    logic                 touched;
    logic [4:0]           per_write;
    logic [4:0]           rd_cnt;

    assign accept  = desc_valid && desc_ready;
    assign in_mode = desc_words[W_CTRL*32 + MODE_LO +: 4];
    assign in_nbuf = desc_words[W_CTRL*32 + NBUF_LO +: 4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_id    <= '0;
            lat_irq   <= 1'b0;
            lat_nop   <= 1'b0;
            touched   <= 1'b0;
            per_write <= '0;
            rd_cnt    <= '0;
        end else if (accept) begin
            lat_id    <= desc_words[XDE_IDW-1:0];
            lat_irq   <= desc_words[W_CTRL*32 + IRQ_BIT];
            lat_nop   <= (in_mode == OP_NOP);
            per_write <= (in_mode == OP_COPY) ? 5'd1 : {1'b0, in_nbuf};
            touched   <= 1'b0;
            rd_cnt    <= '0;
        end else begin
            if (mem_req && mem_gnt) begin
                touched <= 1'b1;
            end
            if (mem_req && mem_gnt && !mem_we) begin
                rd_cnt <= rd_cnt + 5'd1;
            end else if (mem_req && mem_gnt && mem_we) begin
                rd_cnt <= '0;
            end
        end
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !desc_ready);

    a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> desc_ready);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_tags: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_id == lat_id && done_irq == lat_irq));

    a_r3_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_nop) |-> (!touched && !done_err));

    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> !touched);

    a_r5_reads_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_gnt) |-> (rd_cnt == per_write));

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    a_r10_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_ready || done) |-> !mem_req);

    logic unused_chk;
    assign unused_chk = ^{mem_rdata, desc_words};

endmodule

bind xor_desc_engine xde_checks #(.MAX_SRC(MAX_SRC)) u_chk (.*);

// File: tb/sim_xor_desc_engine.sv
module sim_xor_desc_engine;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [1023:0] desc_words = '0;
    logic          mem_req;
    logic          mem_we;
    logic [47:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_gnt = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          done;
    logic [15:0]   done_id;
    logic          done_irq;
    logic          done_err;

    xor_desc_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .desc_ready (desc_ready),
        .desc_words (desc_words),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .done_id    (done_id),
        .done_irq   (done_irq),
        .done_err   (done_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // memory image is a pure function of the address
    function automatic logic [31:0] pat(input logic [47:0] a);
        return (a[31:0] * 32'h9E3779B1) ^ {a[47:32], a[47:32]} ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder with pseudo-random stalls
    logic          no_stall = 1'b0;
    logic [7:0]    lfsr = 8'h5B;
    logic          prev_wait = 1'b0;
    logic [47:0]   prev_addr = '0;
    logic          prev_we = 1'b0;
    logic [31:0]   prev_wdata = '0;
    int            hold_seen = 0;
    int            hold_viol = 0;
    logic          lg_we   [$];
    logic [47:0]   lg_addr [$];
    logic [31:0]   lg_data [$];

    always @(negedge clk) begin
        if (prev_wait) begin
            hold_seen++;
            if (!mem_req || mem_addr != prev_addr || mem_we != prev_we ||
                (prev_we && mem_wdata != prev_wdata))
                hold_viol++;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt   = mem_req && (no_stall || lfsr[0]);
        mem_rdata = pat(mem_addr);
        if (mem_req && mem_gnt) begin
            lg_we.push_back(mem_we);
            lg_addr.push_back(mem_addr);
            lg_data.push_back(mem_wdata);
        end
        prev_wait  = mem_req && !mem_gnt;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wdata = mem_wdata;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [47:0] src_tbl [8];
    logic [47:0] copy_src;
    logic [15:0] id_ctr = 16'hA5F0;

    task automatic run_desc(input logic [3:0] mode, input logic irq, input logic p_en,
                            input logic [3:0] nbuf, input logic [31:0] len,
                            input logic [47:0] dst, input string req);
        logic [31:0] dw [32];
        logic [15:0] id;
        logic        exp_bad;
        logic        exp_moves;
        logic [32:0] tmp;
        int          nw;
        int          nsrc;
        int          cyc;
        int          idx;
        bit          seq_ok;
        logic [47:0] sa;
        logic [31:0] acc;
        id = id_ctr;
        id_ctr = id_ctr + 16'h0137;
        for (int i = 0; i < 32; i++) dw[i] = (i >= 20) ? 32'h7777_7777 : 32'h0;
        dw[0] = {16'hFFFF, id};
        dw[1] = 32'hDEAD_BEEF;
        dw[2] = {mode, irq, 1'b1, nbuf, 4'b1010, p_en, 1'b1, 16'h1234};
        dw[3] = len;
        dw[4] = copy_src[31:0];
        dw[5] = {16'hCAFE, copy_src[47:32]};
        dw[6] = dst[31:0];
        dw[7] = {16'hF00D, dst[47:32]};
        for (int i = 0; i < 8; i++) begin
            int p;
            p = 8 + 3 * (i / 2);
            if ((i % 2) == 0) begin
                dw[p] = src_tbl[i][31:0];
                dw[p+2][15:0] = src_tbl[i][47:32];
            end else begin
                dw[p+1] = src_tbl[i][31:0];
                dw[p+2][31:16] = src_tbl[i][47:32];
            end
        end
        exp_bad = !(mode == 4'd0 || mode == 4'd1 ||
                    (mode == 4'd6 && p_en && nbuf >= 4'd1 && nbuf <= 4'd8));
        exp_moves = !exp_bad && mode != 4'd0;
        tmp  = {1'b0, len} + 33'd3;
        nw   = int'(tmp[32:2]);
        nsrc = (mode == 4'd1) ? 1 : int'(nbuf);

        @(negedge clk);
        chk(desc_ready == 1'b1, "R1", "ready before offer", 64'(desc_ready), 64'd1);
        for (int i = 0; i < 32; i++) desc_words[i*32 +: 32] = dw[i];
        lg_we.delete();
        lg_addr.delete();
        lg_data.delete();
        desc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, req, "completion seen", 64'(done), 64'd1);
        chk(desc_ready == 1'b0, "R1", "ready low at done", 64'(desc_ready), 64'd0);
        chk(done_id == id, "R2", "returned id", 64'(done_id), 64'(id));
        chk(done_irq == irq, "R2", "returned irq flag", 64'(done_irq), 64'(irq));
        chk(done_err == exp_bad, req, "error status", 64'(done_err), 64'(exp_bad));
        if (!exp_moves || nw == 0) begin
            chk(cyc == 1, req, "immediate completion latency", 64'(cyc), 64'd1);
            chk(lg_we.size() == 0, req, "no memory access", 64'(lg_we.size()), 64'd0);
        end else begin
            chk(lg_we.size() == nw * (nsrc + 1), req, "access count",
                64'(lg_we.size()), 64'(nw * (nsrc + 1)));
            seq_ok = 1'b1;
            idx = 0;
            for (int k = 0; k < nw && seq_ok; k++) begin
                acc = '0;
                for (int s = 0; s < nsrc && seq_ok; s++) begin
                    sa = ((mode == 4'd1) ? copy_src : src_tbl[s]) + 48'(4 * k);
                    acc = acc ^ pat(sa);
                    if (idx >= lg_we.size() || lg_we[idx] != 1'b0 || lg_addr[idx] != sa) begin
                        seq_ok = 1'b0;
                        chk(1'b0, req, "read address order",
                            (idx < lg_addr.size()) ? 64'(lg_addr[idx]) : 64'd0, 64'(sa));
                    end
                    idx++;
                end
                if (seq_ok) begin
                    sa = dst + 48'(4 * k);
                    if (idx >= lg_we.size() || lg_we[idx] != 1'b1 || lg_addr[idx] != sa ||
                        lg_data[idx] != acc) begin
                        seq_ok = 1'b0;
                        chk(1'b0, req, "write address/data",
                            (idx < lg_data.size()) ? {lg_addr[idx][31:0], lg_data[idx]} : 64'd0,
                            {sa[31:0], acc});
                    end
                    idx++;
                end
            end
            if (seq_ok) chk(1'b1, req, "access sequence", 64'd0, 64'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++)
            src_tbl[i] = {16'h0A50 + 16'(i * 16'h0111), 32'h1000_0000 + 32'(i * 32'h1000)};
        copy_src = 48'h3C21_2000_0040;

        repeat (3) @(negedge clk);
        chk(desc_ready == 1'b1, "R1", "ready in reset", 64'(desc_ready), 64'd1);
        chk(done == 1'b0, "R2", "done in reset", 64'(done), 64'd0);
        chk(mem_req == 1'b0, "R10", "req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1'b1 && mem_req == 1'b0, "R10", "idle after reset",
            64'({desc_ready, mem_req}), 64'h2);

        // no-op with and without interrupt request
        run_desc(4'd0, 1'b1, 1'b0, 4'd0, 32'd100, 48'hD000_4000_0000, "R3");
        run_desc(4'd0, 1'b0, 1'b1, 4'd3, 32'd0, 48'hD000_4000_0000, "R3");

        // copy over a sweep of byte counts, including zero and odd counts
        for (int n = 0; n <= 9; n++)
            run_desc(4'd1, n[0], 1'b0, 4'd0, 32'(n), 48'hD001_5000_0000 + 48'(n * 256),
                     (n == 0) ? "R6" : "R4");
        no_stall = 1'b1;
        run_desc(4'd1, 1'b1, 1'b0, 4'd5, 32'd64, 48'hD002_6000_0000, "R4");
        no_stall = 1'b0;

        // XOR: every buffer count with P enabled, plus a ragged byte count
        for (int b = 1; b <= 8; b++)
            run_desc(4'd6, 1'b1, 1'b1, 4'(b), 32'd12, 48'hD003_7000_0000 + 48'(b * 256), "R5");
        run_desc(4'd6, 1'b0, 1'b1, 4'd7, 32'd5, 48'hD004_7100_0000, "R5");
        run_desc(4'd6, 1'b0, 1'b1, 4'd8, 32'd0, 48'hD004_7200_0000, "R6");

        // malformed XOR
        run_desc(4'd6, 1'b1, 1'b0, 4'd3, 32'd16, 48'hD005_0000_0000, "R8");
        for (int b = 0; b <= 15; b++)
            if (b == 0 || b > 8)
                run_desc(4'd6, b[0], 1'b1, 4'(b), 32'd16, 48'hD005_0000_0000, "R8");

        // every unexecuted operation code
        for (int m = 2; m <= 15; m++)
            if (m != 6)
                run_desc(4'(m), m[0], 1'b1, 4'd2, 32'd8, 48'hD006_0000_0000, "R7");

        chk(hold_viol == 0 && hold_seen > 0, "R9", "stalled request held",
            64'(hold_viol), 64'd0);
        @(negedge clk);
        chk(desc_ready == 1'b1 && done == 1'b0, "R1", "idle after last completion",
            64'({desc_ready, done}), 64'h2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule